// File: doc/BRIEF.md
# Serial Packed-BCD Field Arithmetic Unit

This unit performs decimal arithmetic on multi-byte packed-BCD numbers held in a byte-wide internal RAM. Each byte holds two decimal digits, with the high nibble as the more significant digit. A request selects one of several operations:

- add or subtract the accumulator value into the number at the destination pointer;
- add or subtract the number at a second pointer into the destination number;
- shift the destination field by one digit, left or right.

The field is `len_i + 1` bytes long. The unit works through it one byte at a time. Between bytes it passes the decimal carry or borrow. For shifts it passes the displaced digit instead.

The unit reads and writes the RAM through a single address/write port. Read data must be valid in the same cycle as the address. The carry and zero flags are updated when an arithmetic request completes. A one-cycle done pulse marks the end of every request, and a busy level covers the whole request.

Top module: `bcd_field_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `ram_we_o`, `c_o` and `z_o` are 0.
- R2: `start_i` is accepted only when the unit is idle and `op_i` is a valid code. The valid codes are 0 add-A, 1 subtract-A, 2 add-Q, 3 subtract-Q, 4 shift-right and 5 shift-left. Codes 6 and 7, and any `start_i` seen while busy, have no effect.
- R3: Every digit of an add or subtract result is decimally corrected. A digit sum above 9 yields sum+6 modulo 16 and a carry into the next digit. A negative digit difference yields difference-6 modulo 16 and a borrow.
- R4: Add-A adds `acc_i` to the byte at `p_i`, which is the least significant byte. The bytes at `p_i-1` down to `p_i-len_i` receive only the carry passed up from the previous byte. `len_i`=0 processes exactly one byte.
- R5: Subtract-A subtracts `acc_i` from the least significant byte at `p_i`. The more significant bytes, at decreasing addresses, absorb only the borrow.
- R6: Add-Q adds the number at `q_i` to the number at `p_i` and writes the sum to `p_i`. Both pointers start at the least significant byte and decrement together.
- R7: Subtract-Q writes (P) minus (Q) to the P field, with the same pointer walk as R6.
- R8: At the done pulse of an arithmetic request, `c_o` holds the final carry or borrow out of the most significant byte. At the same pulse, `z_o` is 1 exactly when every written byte is zero. The flags change at no other time.
- R9: Shift-left treats `p_i` as the least significant byte and walks downward through the addresses. Each byte becomes {its own low digit, incoming digit}. The first incoming digit is 0, and the byte's old high digit is passed on to the next byte. Flags are left unchanged.
- R10: Shift-right treats `p_i` as the most significant byte and walks upward through the addresses. Each byte becomes {incoming digit, its own high digit}. The first incoming digit is 0, and the byte's old low digit is passed on to the next byte. Flags are left unchanged.
- R11: Timing is as follows:
  - Each byte takes 2 cycles (read P, write P) for codes 0, 1, 4 and 5.
  - Each byte takes 3 cycles (read P, read Q, write P) for codes 2 and 3.
  - `busy_o` is high for exactly bytes×cycles, starting in the cycle after acceptance.
  - `done_o` pulses for one cycle right after the last write.
  - A new start asserted during that done cycle is accepted.
- R12: Pointer arithmetic wraps modulo 2^ADDR_W (128 bytes by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (see R2) |
| p_i | input | ADDR_W | Destination field pointer |
| q_i | input | ADDR_W | Source field pointer |
| len_i | input | LEN_W | Field length minus one |
| acc_i | input | DATA_W | Accumulator operand |
| ram_rdata_i | input | DATA_W | RAM read data for `ram_addr_o`, same cycle |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | DATA_W | RAM write data |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| c_o | output | 1 | Carry/borrow flag |
| z_o | output | 1 | Zero flag |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. In that cycle the flags of the finishing operation are published while the next operation latches its operands. The bench provokes this by raising `start_i` in the very cycle `done_o` is high, with the second operation reading bytes the first one just wrote. It then judges both requests against its own model:
- the first request's flags at its done pulse;
- the second request's per-cycle busy level;
- every write address and data value of the second request.

// File: rtl/bcd_unit_pkg.sv
package bcd_unit_pkg;

  typedef enum logic [2:0] {
    OP_ADD_A = 3'd0,
    OP_SUB_A = 3'd1,
    OP_ADD_Q = 3'd2,
    OP_SUB_Q = 3'd3,
    OP_SHR   = 3'd4,
    OP_SHL   = 3'd5
  } bcd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_P = 2'd1,
    ST_RD_Q = 2'd2,
    ST_WR   = 2'd3
  } bcd_state_e;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_uses_q(input logic [2:0] op);
    return (op == OP_ADD_Q) || (op == OP_SUB_Q);
  endfunction

  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_SUB_A) || (op == OP_SUB_Q);
  endfunction

  function automatic logic op_is_shift(input logic [2:0] op);
    return (op == OP_SHR) || (op == OP_SHL);
  endfunction

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       sub_i,
  input  logic       cin_i,
  output logic [3:0] d_o,
  output logic       cout_o
);

  logic [4:0] raw;

  always_comb begin
    if (sub_i) begin
      raw    = {1'b0, a_i} - {1'b0, b_i} - {4'd0, cin_i};
      cout_o = raw[4];
      d_o    = raw[4] ? raw[3:0] - 4'd6 : raw[3:0];
    end else begin
      raw    = {1'b0, a_i} + {1'b0, b_i} + {4'd0, cin_i};
      cout_o = raw > 5'd9;
      d_o    = cout_o ? raw[3:0] + 4'd6 : raw[3:0];
    end
    if (!$isunknown({a_i, b_i, sub_i, cin_i}) && a_i <= 4'd9 && b_i <= 4'd9)
      AST_DIGIT_RANGE: assert (d_o <= 4'd9) else $error("digit out of range");  // R3
  end

endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);

  localparam int NIBBLES = DATA_W / 4;

  logic [NIBBLES:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_digit
    bcd_digit u_digit (
      .a_i   (a_i[4*g +: 4]),
      .b_i   (b_i[4*g +: 4]),
      .sub_i (sub_i),
      .cin_i (carry[g]),
      .d_o   (sum_o[4*g +: 4]),
      .cout_o(carry[g+1])
    );
  end

  assign cout_o = carry[NIBBLES];

endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_unit_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] p_i,
  input  logic [ADDR_W-1:0] q_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              accept_o,
  output logic              rd_p_o,
  output logic              rd_q_o,
  output logic              wr_o,
  output logic              first_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        op_o,
  output logic              busy_o,
  output logic              done_o
);

  bcd_state_e        state_q;
  logic [ADDR_W-1:0] p_ptr_q, q_ptr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              first_q, done_q;
  logic [2:0]        op_q;

  assign accept_o = (state_q == ST_IDLE) && start_i && op_valid(op_i);
  assign rd_p_o   = state_q == ST_RD_P;
  assign rd_q_o   = state_q == ST_RD_Q;
  assign wr_o     = state_q == ST_WR;
  assign first_o  = first_q;
  assign last_o   = cnt_q == '0;
  assign addr_o   = rd_q_o ? q_ptr_q : p_ptr_q;
  assign op_o     = op_q;
  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      p_ptr_q <= '0;
      q_ptr_q <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          op_q    <= op_i;
          p_ptr_q <= p_i;
          q_ptr_q <= q_i;
          cnt_q   <= len_i;
          first_q <= 1'b1;
          state_q <= ST_RD_P;
        end
        ST_RD_P: state_q <= op_uses_q(op_q) ? ST_RD_Q : ST_WR;
        ST_RD_Q: state_q <= ST_WR;
        ST_WR: begin
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q   <= cnt_q - 1'b1;
            first_q <= 1'b0;
            // right shift walks toward higher addresses, all else downward
            p_ptr_q <= (op_q == OP_SHR) ? p_ptr_q + 1'b1 : p_ptr_q - 1'b1;
            q_ptr_q <= q_ptr_q - 1'b1;
            state_q <= ST_RD_P;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done longer than one cycle");  // R11

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o) else $error("accepted start did not raise busy");  // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(op_q) && $stable(cnt_q == '0 ? 1'b0 : 1'b0))
    else $error("start while busy altered request");  // R2

  AST_BAD_OP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !op_valid(op_i)) |=> !busy_o)
    else $error("invalid op started");  // R2

endmodule

// File: rtl/bcd_field_unit.sv
module bcd_field_unit
  import bcd_unit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] p_i,
  input  logic [ADDR_W-1:0] q_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              c_o,
  output logic              z_o
);

  localparam int NIB_W = 4;

  logic              accept, rd_p, rd_q, wr, first, last;
  logic [2:0]        op;
  logic [DATA_W-1:0] dst_q, src_q, acc_q;
  logic [DATA_W-1:0] alu_b, alu_sum, shift_res, wdata;
  logic [NIB_W-1:0]  nib_q, nib_in;
  logic              carry_q, zacc_q, alu_cin, alu_cout, z_run;
  logic              c_q, z_q;

  bcd_seq #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .p_i     (p_i),
    .q_i     (q_i),
    .len_i   (len_i),
    .accept_o(accept),
    .rd_p_o  (rd_p),
    .rd_q_o  (rd_q),
    .wr_o    (wr),
    .first_o (first),
    .last_o  (last),
    .addr_o  (ram_addr_o),
    .op_o    (op),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // accumulator only feeds the least significant byte
  assign alu_b   = op_uses_q(op) ? src_q : (first ? acc_q : '0);
  assign alu_cin = first ? 1'b0 : carry_q;

  bcd_byte_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (dst_q),
    .b_i   (alu_b),
    .sub_i (op_is_sub(op)),
    .cin_i (alu_cin),
    .sum_o (alu_sum),
    .cout_o(alu_cout)
  );

  assign nib_in    = first ? '0 : nib_q;
  assign shift_res = (op == OP_SHL) ? {dst_q[DATA_W-NIB_W-1:0], nib_in}
                                    : {nib_in, dst_q[DATA_W-1:NIB_W]};
  assign wdata     = op_is_shift(op) ? shift_res : alu_sum;
  assign z_run     = (first | zacc_q) & (wdata == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      src_q   <= '0;
      acc_q   <= '0;
      nib_q   <= '0;
      carry_q <= 1'b0;
      zacc_q  <= 1'b0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      if (accept) acc_q <= acc_i;
      if (rd_p)   dst_q <= ram_rdata_i;
      if (rd_q)   src_q <= ram_rdata_i;
      if (wr) begin
        carry_q <= alu_cout;
        zacc_q  <= z_run;
        nib_q   <= (op == OP_SHL) ? dst_q[DATA_W-1 -: NIB_W] : dst_q[NIB_W-1:0];
        if (last && !op_is_shift(op)) begin
          c_q <= alu_cout;
          z_q <= z_run;
        end
      end
    end
  end

  assign ram_we_o    = wr;
  assign ram_wdata_o = wdata;
  assign c_o         = c_q;
  assign z_o         = z_q;

  AST_FLAGS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({c_q, z_q}) |-> done_o) else $error("flags moved outside done");  // R8

  AST_SHIFT_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_is_shift(op)) |-> $stable({c_q, z_q}))
    else $error("shift altered flags");  // R9

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_o && !done_o) else $error("write outside request");  // R11

endmodule

// File: tb/test_bcd_field_unit.sv
`timescale 1ns/1ps
module test_bcd_field_unit;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [6:0] p_i = '0, q_i = '0;
  logic [7:0] len_i = '0, acc_i = '0;
  logic [7:0] ram_rdata_i;
  logic [6:0] ram_addr_o;
  logic       ram_we_o, busy_o, done_o, c_o, z_o;
  logic [7:0] ram_wdata_o;

  logic [7:0] mem [128];
  int checks = 0, errors = 0;
  int exp_c = 0, exp_z = 0;
  int exp_addr[$], exp_data[$];

  always #5 clk_i = ~clk_i;

  assign ram_rdata_i = mem[ram_addr_o];
  always @(posedge clk_i) if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;

  bcd_field_unit i_bcd_field_unit (
    .clk_i, .rst_ni, .start_i, .op_i, .p_i, .q_i, .len_i, .acc_i,
    .ram_rdata_i, .ram_addr_o, .ram_we_o, .ram_wdata_o,
    .busy_o, .done_o, .c_o, .z_o
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int rbcd();
    return ((($urandom % 10) << 4) | ($urandom % 10));
  endfunction

  // behavioural reference: builds expected write sequence and flags
  task automatic model(input int op, input int p, input int q, input int len, input int acc);
    int sh [128];
    int pa, qa, cr, cn, zz, x, y, t, r;
    bit sub;
    for (int i = 0; i < 128; i++) sh[i] = mem[i];
    exp_addr.delete();
    exp_data.delete();
    pa = p; qa = q; cr = 0; cn = 0; zz = 1;
    for (int b = 0; b <= len; b++) begin
      x = sh[pa];
      if (op <= 3) begin
        y = (op >= 2) ? sh[qa] : ((b == 0) ? acc : 0);
        sub = (op == 1) || (op == 3);
        r = 0;
        for (int d = 0; d < 2; d++) begin
          int xd = (x >> (4*d)) % 16;
          int yd = (y >> (4*d)) % 16;
          if (!sub) begin
            t = xd + yd + cr;
            if (t > 9) begin t -= 10; cr = 1; end else cr = 0;
          end else begin
            t = xd - yd - cr;
            if (t < 0) begin t += 10; cr = 1; end else cr = 0;
          end
          r += t << (4*d);
        end
      end else if (op == 5) begin
        r = ((x % 16) * 16) + cn;
        cn = x / 16;
      end else begin
        r = cn * 16 + x / 16;
        cn = x % 16;
      end
      sh[pa] = r;
      exp_addr.push_back(pa);
      exp_data.push_back(r);
      if (r != 0) zz = 0;
      pa = (op == 4) ? (pa + 1) % 128 : (pa + 127) % 128;
      qa = (qa + 127) % 128;
    end
    if (op <= 3) begin
      exp_c = cr;
      exp_z = zz;
    end
  endtask

  task automatic run_op(input int op, input int p, input int q, input int len, input int acc,
                        input bit b2b, input bit poke, input string tag);
    int total, ea, ed;
    if (!b2b) @(negedge clk_i);
    model(op, p, q, len, acc);
    total = (len + 1) * ((op == 2 || op == 3) ? 3 : 2);
    start_i = 1'b1; op_i = 3'(op); p_i = 7'(p); q_i = 7'(q); len_i = 8'(len); acc_i = 8'(acc);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int cyc = 0; cyc < total; cyc++) begin
      if (poke && cyc == 0) begin
        start_i = 1'b1; op_i = 3'd5; p_i = 7'h05; len_i = 8'd0;
      end
      if (poke && cyc == 1) start_i = 1'b0;
      chk(busy_o === 1'b1, "R11", {tag, " busy in window"}, busy_o, 1);
      if (ram_we_o) begin
        if (exp_addr.size() == 0) begin
          chk(1'b0, tag, "unexpected write", ram_addr_o, -1);
        end else begin
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          chk(ram_addr_o == 7'(ea), tag, "write address", ram_addr_o, ea);
          chk(ram_wdata_o == 8'(ed), tag, "write data", ram_wdata_o, ed);
        end
      end
      @(negedge clk_i);
    end
    chk(busy_o === 1'b0, "R11", {tag, " busy after"}, busy_o, 0);
    chk(done_o === 1'b1, "R11", {tag, " done pulse"}, done_o, 1);
    chk(exp_addr.size() == 0, tag, "missing writes", exp_addr.size(), 0);
    chk(c_o == 1'(exp_c), "R8", {tag, " carry flag"}, c_o, exp_c);
    chk(z_o == 1'(exp_z), "R8", {tag, " zero flag"}, z_o, exp_z);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    for (int i = 0; i < 128; i++) mem[i] = 8'(rbcd());
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, ram_we_o, c_o, z_o} == 5'b0, "R1", "outputs in reset", {busy_o, done_o, ram_we_o, c_o, z_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, done_o, ram_we_o, c_o, z_o} == 5'b0, "R1", "outputs after reset", {busy_o, done_o, ram_we_o, c_o, z_o}, 0);

    // R3/R4 single byte, both digits corrected
    mem[8'h20] = 8'h45;
    run_op(0, 8'h20, 0, 0, 8'h37, 0, 0, "R4");
    chk(mem[8'h20] == 8'h82, "R3", "digit correction", mem[8'h20], 8'h82);
    // R4 carry ripple through three bytes
    mem[8'h30] = 8'h99; mem[8'h2F] = 8'h99; mem[8'h2E] = 8'h99;
    run_op(0, 8'h30, 0, 2, 8'h01, 0, 0, "R4");
    // R5 borrow across bytes, then borrow out
    mem[8'h40] = 8'h00; mem[8'h3F] = 8'h10;
    run_op(1, 8'h40, 0, 1, 8'h01, 0, 0, "R5");
    mem[8'h44] = 8'h00;
    run_op(1, 8'h44, 0, 0, 8'h01, 0, 0, "R5");
    // R6/R7 field with second operand
    run_op(2, 8'h50, 8'h60, 3, 0, 0, 0, "R6");
    run_op(3, 8'h50, 8'h60, 3, 0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) mem[8'h70 - i] = mem[8'h68 - i];
    run_op(3, 8'h70, 8'h68, 2, 0, 0, 0, "R7");
    chk(z_o == 1'b1, "R8", "equal operands zero", z_o, 1);
    mem[8'h10] = 8'h00; mem[8'h18] = 8'h01;
    run_op(3, 8'h10, 8'h18, 0, 0, 0, 0, "R7");
    chk(c_o == 1'b1, "R8", "borrow out", c_o, 1);
    // R9/R10 digit shifts, flags held
    run_op(5, 8'h28, 0, 2, 0, 0, 0, "R9");
    run_op(4, 8'h08, 0, 2, 0, 0, 0, "R10");
    // R12 pointer wrap
    run_op(2, 8'h01, 8'h50, 3, 0, 0, 0, "R12");
    run_op(4, 8'h7E, 0, 3, 0, 0, 0, "R12");
    // R2 invalid op ignored
    snap = mem[8'h22];
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd6; p_i = 7'h22; len_i = 8'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy_o == 1'b0 && ram_we_o == 1'b0, "R2", "invalid op started", {busy_o, ram_we_o}, 0);
      @(negedge clk_i);
    end
    chk(mem[8'h22] == 8'(snap), "R2", "invalid op touched RAM", mem[8'h22], snap);
    // R2 start while busy ignored
    run_op(2, 8'h48, 8'h58, 4, 0, 0, 1, "R2");
    // R11 back-to-back: start in the done cycle, second op reads first op's result
    run_op(0, 8'h38, 0, 3, 8'h58, 0, 0, "R11");
    run_op(1, 8'h38, 0, 3, 8'h27, 1, 0, "R11");
    // long field
    run_op(2, 8'h3F, 8'h7F, 20, 0, 0, 0, "R6");
    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule